// File: doc/BRIEF.md
# Trapping Add/Subtract Execution Unit

This unit is the integer add/subtract stage of a simple RISC pipeline. It runs six operations: add, add with a 16-bit immediate, and subtract, each in a trapping (signed) and a non-trapping (unsigned) form. One adder serves all six. Subtraction feeds the inverted second operand and a carry-in of one into that adder. Two's-complement overflow is computed for every legal operation. Only the trapping forms act on it.

When a trapping operation overflows, the unit drops the destination write. It records the instruction address in an exception program counter (EPC) and points the next fetch address at a fixed handler vector. Otherwise the next fetch address is the instruction address plus four. The EPC value is always visible on a read port, so a move-from-control operation can copy it out.

Operations enter on a valid/ready interface and leave on another, through one output register. An operation is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds and no new operation is taken.

Top module: `arith_trap_unit`

## Requirements
- R1: Opcode 0 gives a+b, opcode 2 gives a-b, opcode 3 gives a+b and opcode 5 gives a-b. Each result is taken modulo 2^XLEN.
- R2: Opcode 1 (trapping) and opcode 4 (non-trapping) give a + imm. `in_imm` is sign-extended to XLEN bits for both, and `in_b` is ignored.
- R3: `out_ovf` is 1 exactly when the signed result falls outside the XLEN-bit two's-complement range. An add of operands with opposite signs never sets it. A subtract of operands with the same sign never sets it.
- R4: For opcodes 0, 1 and 2 with overflow, the unit sets `out_trap`=1 and `out_wen`=0 and drives `out_next_pc`=TRAP_VECTOR.
- R5: Opcodes 3, 4 and 5 never trap. They give `out_wen`=1 and `out_next_pc`=`in_pc`+4, even when they overflow.
- R6: `epc_value` is 0 after reset. It loads `in_pc` at the edge that accepts a trapping overflow, and holds its value otherwise.
- R7: Opcodes 6 and 7 are undefined. They give result 0 with `out_wen`, `out_ovf` and `out_trap` all 0, and `out_next_pc`=`in_pc`+4.
- R8: `in_ready` = !`out_valid` || `out_ready`. The result appears with `out_valid` one cycle after acceptance. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R9: During reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Opcode (0 add, 1 add-imm, 2 sub, 3 add-u, 4 add-imm-u, 5 sub-u) |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_imm | input | IMMW | Immediate, sign-extended |
| in_pc | input | XLEN | Instruction address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | XLEN | Sum or difference |
| out_wen | output | 1 | Destination write enable |
| out_ovf | output | 1 | Overflow detected |
| out_trap | output | 1 | Overflow exception raised |
| out_next_pc | output | XLEN | Next fetch address |
| epc_value | output | XLEN | Exception program counter read port |

## Verification
The hardest case to reach from the ports is a trap result held under back-pressure while the EPC has already moved. A second trap must then be blocked from overwriting that EPC until the first result drains. The bench reaches this with an 8-bit configuration that sweeps every first operand against a set of corner second operands and all 16 immediates. It includes subtracting the most negative value. During the sweep `out_ready` is withheld for several cycles on a regular pattern, and the outputs, the EPC and `in_ready` are checked on each held cycle.

// File: rtl/arith_trap_pkg.sv
package arith_trap_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADDI  = 3'd1,
    OP_SUB   = 3'd2,
    OP_ADDU  = 3'd3,
    OP_ADDIU = 3'd4,
    OP_SUBU  = 3'd5
  } op_e;
endpackage

// File: rtl/trap_operand_sel.sv
module trap_operand_sel
  import arith_trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] opnd_o,
  output logic            sub_o,
  output logic            trap_en_o,
  output logic            legal_o
);
  logic [XLEN-1:0] imm_ext;

  generate
    if (IMMW < XLEN) begin : g_extend
      assign imm_ext = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    opnd_o    = b_i;
    sub_o     = 1'b0;
    trap_en_o = 1'b0;
    legal_o   = 1'b1;
    case (op_i)
      OP_ADD:   trap_en_o = 1'b1;
      OP_ADDI:  begin opnd_o = imm_ext; trap_en_o = 1'b1; end
      OP_SUB:   begin sub_o = 1'b1; trap_en_o = 1'b1; end
      OP_ADDU:  ;
      OP_ADDIU: opnd_o = imm_ext;
      OP_SUBU:  sub_o = 1'b1;
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trap_addsub.sv
module trap_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o
);
  localparam int MSB = XLEN - 1;
  logic [XLEN-1:0] b_eff;

  // Subtract = add inverted operand plus carry-in one.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + XLEN'(sub_i);
  assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

  always_comb begin
    // R3: mixed-sign add and same-sign subtract cannot overflow
    if (!sub_i && (a_i[MSB] != b_i[MSB]))
      a_r3_mixed_add: assert (!ovf_o);
    if (sub_i && (a_i[MSB] == b_i[MSB]))
      a_r3_same_sub: assert (!ovf_o);
  end
endmodule

// File: rtl/trap_epc_reg.sv
module trap_epc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] epc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc_o <= '0;
    else if (load_i) epc_o <= pc_i;
  end
endmodule

// File: rtl/arith_trap_unit.sv
module arith_trap_unit
  import arith_trap_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              IMMW        = 16,
  parameter logic [XLEN-1:0] TRAP_VECTOR = XLEN'(32'h8000_0180)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [IMMW-1:0] in_imm,
  input  logic [XLEN-1:0] in_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_wen,
  output logic            out_ovf,
  output logic            out_trap,
  output logic [XLEN-1:0] out_next_pc,
  output logic [XLEN-1:0] epc_value
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0] opnd_b, sum;
  logic            sub_mode, trap_en, legal, ovf, trap_now, fire;

  trap_operand_sel #(.XLEN(XLEN), .IMMW(IMMW)) u_sel (
    .op_i(in_op), .b_i(in_b), .imm_i(in_imm), .opnd_o(opnd_b),
    .sub_o(sub_mode), .trap_en_o(trap_en), .legal_o(legal)
  );

  trap_addsub #(.XLEN(XLEN)) u_add (
    .a_i(in_a), .b_i(opnd_b), .sub_i(sub_mode), .sum_o(sum), .ovf_o(ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign trap_now = legal && trap_en && ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wen     <= 1'b0;
      out_ovf     <= 1'b0;
      out_trap    <= 1'b0;
      out_next_pc <= '0;
    end else if (fire) begin
      out_valid   <= 1'b1;
      out_result  <= legal ? sum : '0;
      out_wen     <= legal && !trap_now;
      out_ovf     <= legal && ovf;
      out_trap    <= trap_now;
      out_next_pc <= trap_now ? TRAP_VECTOR : in_pc + PC_STEP;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  trap_epc_reg #(.XLEN(XLEN)) u_epc (
    .clk(clk), .rst_n(rst_n), .load_i(fire && trap_now),
    .pc_i(in_pc), .epc_o(epc_value)
  );

  // R4: a trap never writes and always redirects
  a_r4_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trap) |-> (!out_wen && out_next_pc == TRAP_VECTOR));
  // R5: unsigned forms never trap
  a_r5_unsigned_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == OP_ADDU || in_op == OP_ADDIU || in_op == OP_SUBU)) |=> !out_trap);
  // R6: EPC moves only on an accepted trap
  a_r6_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && trap_now) |=> $stable(epc_value));
  // R7: undefined opcodes have no effect
  a_r7_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op > 3'd5) |=> (!out_wen && !out_trap && !out_ovf));
  // R8: held outputs stay stable under back-pressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_trap) && $stable(out_wen) && $stable(out_next_pc)));
endmodule

// File: tb/tb_arith_trap_unit.sv
`timescale 1ns/1ps
module tb_arith_trap_unit;
  localparam int XLEN = 8;
  localparam int IMMW = 4;
  localparam logic [7:0] VEC = 8'hC0;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [2:0] in_op = 0;
  logic [7:0] in_a = 0, in_b = 0, in_pc = 0;
  logic [3:0] in_imm = 0;
  logic [7:0] out_result, out_next_pc, epc_value;
  logic out_wen, out_ovf, out_trap;

  int checks = 0, errors = 0;
  logic [7:0] epc_exp = 0;
  logic [7:0] pc_cnt = 8'h10;

  always #2.5 clk = ~clk;

  arith_trap_unit #(.XLEN(XLEN), .IMMW(IMMW), .TRAP_VECTOR(VEC)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wen(out_wen), .out_ovf(out_ovf), .out_trap(out_trap),
    .out_next_pc(out_next_pc), .epc_value(epc_value)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] b_pick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h7F;  3: return 8'h80;
      4: return 8'h81;  5: return 8'hFF;  6: return 8'hFE;  7: return 8'h40;
      default: return 8'((i * 37) + 11);
    endcase
  endfunction

  logic [18:0] exp_pack;
  string exp_tag;

  // Expected outputs from the requirements, signed arithmetic on ints
  task automatic model(input int op, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] imm, input logic [7:0] pc);
    int bv, sa, sb, sr;
    bit legal, sub, sgn, ovf, trap;
    logic [7:0] r;
    legal = (op <= 5);
    sub   = (op == 2 || op == 5);
    sgn   = (op <= 2);
    bv    = (op == 1 || op == 4) ? (imm[3] ? int'(imm) - 16 : int'(imm)) : int'(b);
    sa    = a[7] ? int'(a) - 256 : int'(a);
    sb    = (op == 1 || op == 4) ? bv : (b[7] ? int'(b) - 256 : int'(b));
    sr    = sub ? sa - sb : sa + sb;
    r     = 8'(sr);
    ovf   = legal && (sr > 127 || sr < -128);
    trap  = sgn && ovf;
    exp_pack = {legal ? r : 8'h00, legal && !trap, ovf, trap, trap ? VEC : 8'(pc + 8'd4)};
    if (!legal) exp_tag = "R7";
    else if (trap) exp_tag = "R4";
    else if (op == 1 || op == 4) exp_tag = "R2";
    else if (ovf) exp_tag = "R5 R3";
    else exp_tag = "R1";
    if (trap) epc_exp = pc;
  endtask

  task automatic run_op(input int op, input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] imm, input int hold);
    @(negedge clk);
    chk("R8 ready when empty", 32'(in_ready), 32'd1);
    in_valid = 1; in_op = 3'(op); in_a = a; in_b = b; in_imm = imm; in_pc = pc_cnt;
    out_ready = (hold == 0);
    model(op, a, b, imm, pc_cnt);
    @(negedge clk);
    in_valid = 0;
    chk({exp_tag, " result"}, {out_valid, out_result, out_wen, out_ovf, out_trap, out_next_pc},
        {1'b1, exp_pack});
    chk("R6 epc", 32'(epc_value), 32'(epc_exp));
    for (int h = 0; h < hold; h++) begin
      // a second trapping op offered while blocked must not move the EPC
      in_valid = 1; in_op = 3'd0; in_a = 8'h7F; in_b = 8'h7F; in_pc = 8'hEE;
      chk("R8 not ready while held", 32'(in_ready), 32'd0);
      @(negedge clk);
      in_valid = 0;
      chk("R8 held", {out_valid, out_result, out_wen, out_ovf, out_trap, out_next_pc},
          {1'b1, exp_pack});
      chk("R6 epc while held", 32'(epc_value), 32'(epc_exp));
    end
    out_ready = 1;
    @(negedge clk);
    chk("R8 drained", 32'(out_valid), 32'd0);
    pc_cnt = pc_cnt + 8'd4;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state, R6 EPC reset value
    chk("R9 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R9 in_ready in reset", 32'(in_ready), 32'd1);
    chk("R6 epc reset", 32'(epc_value), 32'd0);
    rst_n = 1;

    // Directed corners: R1 basic, R3 min-negative subtract, R5 unsigned overflow
    run_op(0, 8'd7, 8'd6, 4'd0, 0);
    run_op(2, 8'd7, 8'd6, 4'd0, 0);
    run_op(2, 8'h00, 8'h80, 4'd0, 0);
    run_op(5, 8'h00, 8'h80, 4'd0, 0);
    run_op(1, 8'h80, 8'h00, 4'hF, 3);
    run_op(4, 8'h80, 8'h00, 4'hF, 0);
    run_op(6, 8'h7F, 8'h7F, 4'd0, 0);
    run_op(7, 8'h80, 8'h80, 4'd0, 1);

    // R8 throughput: back-to-back acceptance while draining
    @(negedge clk);
    in_valid = 1; in_op = 3'd3; in_a = 8'd1; in_b = 8'd2; in_pc = pc_cnt; out_ready = 1;
    @(negedge clk);
    in_op = 3'd3; in_a = 8'd5; in_b = 8'd9;
    chk("R8 ready while draining", 32'(in_ready), 32'd1);
    chk("R8 first result", 32'(out_result), 32'd3);
    @(negedge clk);
    in_valid = 0;
    chk("R8 second result", 32'(out_result), 32'd14);
    @(negedge clk);

    // Sweep: every a, 16 second operands/immediates, all 8 opcodes
    for (int a = 0; a < 256; a++)
      for (int bi = 0; bi < 16; bi++)
        for (int op = 0; op < 8; op++)
          run_op(op, 8'(a), b_pick(bi), 4'(bi), ((a + bi + op) % 37 == 0) ? 2 : 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule